// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Transceiver (Master/Slave, 8/16-bit)

This block moves data across a four-wire serial peripheral link in either direction at once. In master mode it makes the serial clock from the system clock and shifts its transmit word out while shifting the far end's word in. In slave mode it follows an external serial clock and an active-low select, and it answers only while that select is low. One configuration bit picks 8-bit or 16-bit frames and can be changed between frames. The clock idles low. Data leaves most significant bit first, changes on the falling edge and is sampled on the rising edge.

Software writes transmit words into a buffer. A word moves into the shifter only when a frame starts, so the next word can be written while the current one is on the wire. A finished frame lands in a receive buffer, and software reads it from there. Without FIFO mode each buffer holds one word, which gives plain double buffering. With FIFO mode each buffer holds eight words. Full and empty flags are then available, and two interrupt outputs follow receive-full and transmit-empty. If a frame completes while the receive side is full, the new word is dropped and a sticky overflow flag is set.

Top module: `spi_xcvr`

## Requirements
- R1: After reset, sck_o is 0, sel_n_o is 1, tx_empty and rx_empty are 1, and rx_full, rx_ovf, irq_rxf and irq_txe are 0.
- R2: In master mode (cfg_master=1) with cfg_wide=0, a frame sends the low byte of the transmit word most significant bit first on sdo. sdo changes only while sck_o falls, and sck_o has a period of 2*cfg_half clock cycles and idles at 0 between frames.
- R3: With cfg_wide=1, a frame is 16 bits, again most significant bit first, at the same clock rate.
- R4: The bits on sdi, sampled on the rising edges of the serial clock, form the received word. A one-cycle pulse on rd_en pops the oldest received word, and it appears on rd_data on the next cycle. In 8-bit mode bits 15:8 of that word read 0.
- R5: With cfg_fifo=0 the transmit buffer holds one word, so a second word can be written while a frame is running. tx_full goes high when the buffer holds a word, and a write while tx_full=1 is discarded. Queued words go out back to back.
- R6: With cfg_fifo=1 each buffer holds 8 words. rx_full goes high when 8 words are waiting. irq_rxf follows rx_full and irq_txe follows tx_empty, each one cycle later; both are 0 while cfg_fifo=0.
- R7: If a frame completes while the receive side is full (1 word without FIFO mode, 8 with it), the new word is dropped and rx_ovf is set. rx_ovf stays set until an rd_en pulse clears it.
- R8: In slave mode (cfg_master=0), sck_i edges while sel_n_i=1 shift nothing, complete no frame and take no word from the transmit buffer.
- R9: In master mode sel_n_o is 0 for the whole frame only when cfg_selout=1. With cfg_selout=0 it stays at 1.
- R10: In slave mode, once sel_n_i falls, the next transmit word is taken and its first bit is on sdo before the first rising edge of sck_i. Each rising edge samples sdi and each falling edge shifts sdo, so the word is exchanged in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_wide | input | 1 | 1 = 16-bit frames, 0 = 8-bit frames |
| cfg_fifo | input | 1 | 1 = 8-word buffers, 0 = single-word buffers |
| cfg_selout | input | 1 | Master drives sel_n_o during frames |
| cfg_half | input | 8 | Serial clock half period in system clocks (0 is treated as 1) |
| wr_en | input | 1 | Write one transmit word |
| wr_data | input | 16 | Transmit word (low byte used in 8-bit mode) |
| rd_en | input | 1 | Pop one received word; also clears rx_ovf |
| rd_data | output | 16 | Received word, valid the cycle after rd_en |
| tx_full | output | 1 | Transmit buffer cannot accept a word |
| tx_empty | output | 1 | Transmit buffer holds no word |
| rx_full | output | 1 | Receive buffer at capacity |
| rx_empty | output | 1 | No received word waiting |
| rx_ovf | output | 1 | Sticky: a received word was dropped |
| irq_rxf | output | 1 | Receive-full interrupt (FIFO mode) |
| irq_txe | output | 1 | Transmit-empty interrupt (FIFO mode) |
| sck_o | output | 1 | Serial clock out (master) |
| sel_n_o | output | 1 | Active-low select out (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| sel_n_i | input | 1 | Active-low select in (slave) |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |
| sdo | output | 1 | Serial data out (MOSI as master, MISO as slave) |

## Verification
The bench sends a second frame while the first received word is still unread. A design that overwrote the buffer instead of dropping the word would return the wrong byte and leave rx_ovf clear. It writes a third word while the single transmit buffer is full. A design that accepted that word would send 24 clock pulses instead of 16. It fills all eight FIFO entries in both directions, so an off-by-one in the occupancy count shows up as a missing rx_full, a missing interrupt or a lost byte. In slave mode it toggles sck_i while deselected. A design that shifted then would corrupt the next exchange or pull the waiting word from the transmit buffer too early.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
  typedef enum logic [2:0] {
    EN_IDLE,
    EN_LOAD,
    EN_LO,
    EN_HI,
    EN_GAP
  } eng_st_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RV = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RV;
      q  <= RV;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         single,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign empty = (cnt == '0);
  assign full  = single ? (cnt != '0) : (cnt == (AW+1)'(DEPTH));

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
    end else begin
      if (pop) dout <= mem[rp];
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R5
  AST_FIFO_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R4
  AST_FIFO_CNT_RANGE:     assert property (@(posedge clk) disable iff (rst) cnt <= (AW+1)'(DEPTH)); // R6
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_xcvr_pkg::*;
#(
  parameter int DW   = 16,
  parameter int DIVW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          wide,
  input  logic [DIVW-1:0] half,
  input  logic          tx_avail,
  input  logic [DW-1:0] tx_word,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [DW-1:0] rx_word,
  input  logic          sck_s,
  input  logic          sel_n_s,
  input  logic          sdi_m,
  input  logic          sdi_s,
  output logic          sck_o,
  output logic          sel_act,
  output logic          sdo
);
  localparam int HW = DW / 2;
  localparam int BW = $clog2(DW);

  eng_st_t         st;
  logic [DIVW-1:0] hcnt;
  logic [BW-1:0]   bits;
  logic [DW-1:0]   sh;
  logic            smp, armed, sck_d;
  logic            tick, last, s_rise, s_fall;
  logic [DW-1:0]   nxt;

  assign tick   = (half == '0) || (hcnt == half - DIVW'(1));
  assign last   = (bits == (wide ? BW'(DW-1) : BW'(HW-1)));
  assign s_rise = sck_s & ~sck_d;
  assign s_fall = ~sck_s & sck_d;
  assign nxt    = wide ? {sh[DW-2:0], smp} : {{HW{1'b0}}, sh[HW-2:0], smp};
  assign sdo    = wide ? sh[DW-1] : sh[HW-1];
  assign rx_word = nxt;

  always_comb begin
    if (master) begin
      tx_pop  = (st == EN_IDLE) && tx_avail;
      rx_push = (st == EN_HI) && tick && last;
    end else begin
      tx_pop  = (st == EN_IDLE) && !sel_n_s && !armed && tx_avail;
      rx_push = armed && !sel_n_s && s_fall && last;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= EN_IDLE;
      hcnt    <= '0;
      bits    <= '0;
      sh      <= '0;
      smp     <= 1'b0;
      armed   <= 1'b0;
      sck_d   <= 1'b0;
      sck_o   <= 1'b0;
      sel_act <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (master) begin
        armed <= 1'b0;
        case (st)
          EN_IDLE: begin
            hcnt <= '0;
            if (tx_avail) st <= EN_LOAD;
          end
          EN_LOAD: begin
            sh      <= tx_word;
            sel_act <= 1'b1;
            bits    <= '0;
            hcnt    <= '0;
            st      <= EN_LO;
          end
          EN_LO: begin
            if (tick) begin
              sck_o <= 1'b1;
              smp   <= sdi_m;
              hcnt  <= '0;
              st    <= EN_HI;
            end else hcnt <= hcnt + DIVW'(1);
          end
          EN_HI: begin
            if (tick) begin
              sck_o <= 1'b0;
              sh    <= nxt;
              hcnt  <= '0;
              if (last) begin
                sel_act <= 1'b0;
                st      <= EN_GAP;
              end else begin
                bits <= bits + BW'(1);
                st   <= EN_LO;
              end
            end else hcnt <= hcnt + DIVW'(1);
          end
          EN_GAP: begin
            if (tick) st <= EN_IDLE;
            else hcnt <= hcnt + DIVW'(1);
          end
          default: st <= EN_IDLE;
        endcase
      end else begin
        sck_o   <= 1'b0;
        sel_act <= 1'b0;
        hcnt    <= '0;
        if (sel_n_s) begin
          armed <= 1'b0;
          bits  <= '0;
          st    <= EN_IDLE;
        end else if (!armed) begin
          if (st == EN_LOAD) begin
            sh    <= tx_word;
            armed <= 1'b1;
            bits  <= '0;
            st    <= EN_IDLE;
          end else if (tx_avail) begin
            st <= EN_LOAD;
          end else begin
            sh    <= '0;
            armed <= 1'b1;
            bits  <= '0;
          end
        end else begin
          if (s_rise) smp <= sdi_s;
          if (s_fall) begin
            sh <= nxt;
            if (last) begin
              bits  <= '0;
              armed <= 1'b0;
            end else bits <= bits + BW'(1);
          end
        end
      end
    end
  end

  AST_SCK_LOW_IDLE:  assert property (@(posedge clk) disable iff (rst) (master && st == EN_IDLE) |-> !sck_o); // R2
  AST_SCK_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst) sck_o |-> sel_act); // R9
  AST_SLAVE_NO_POP:  assert property (@(posedge clk) disable iff (rst) (!master && sel_n_s) |-> !tx_pop); // R8
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int DIVW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_master,
  input  logic          cfg_wide,
  input  logic          cfg_fifo,
  input  logic          cfg_selout,
  input  logic [DIVW-1:0] cfg_half,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          tx_full,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          rx_empty,
  output logic          rx_ovf,
  output logic          irq_rxf,
  output logic          irq_txe,
  output logic          sck_o,
  output logic          sel_n_o,
  input  logic          sck_i,
  input  logic          sel_n_i,
  input  logic          sdi,
  output logic          sdo
);
  logic [2:0]    syn_q;
  logic          eng_pop, eng_push, sel_act;
  logic [DW-1:0] tx_word, rx_word;
  logic          tx_push, rx_push, rx_pop;

  spi_sync #(.W(3), .RV(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({sck_i, sel_n_i, sdi}), .q(syn_q)
  );

  assign tx_push = wr_en & ~tx_full;
  assign rx_push = eng_push & ~rx_full;
  assign rx_pop  = rd_en & ~rx_empty;

  spi_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .single(~cfg_fifo), .push(tx_push), .din(wr_data),
    .pop(eng_pop), .dout(tx_word), .full(tx_full), .empty(tx_empty)
  );

  spi_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .single(~cfg_fifo), .push(rx_push), .din(rx_word),
    .pop(rx_pop), .dout(rd_data), .full(rx_full), .empty(rx_empty)
  );

  spi_engine #(.DW(DW), .DIVW(DIVW)) u_eng (
    .clk(clk), .rst(rst), .master(cfg_master), .wide(cfg_wide), .half(cfg_half),
    .tx_avail(~tx_empty), .tx_word(tx_word), .tx_pop(eng_pop),
    .rx_push(eng_push), .rx_word(rx_word),
    .sck_s(syn_q[2]), .sel_n_s(syn_q[1]), .sdi_m(sdi), .sdi_s(syn_q[0]),
    .sck_o(sck_o), .sel_act(sel_act), .sdo(sdo)
  );

  assign sel_n_o = ~(cfg_selout & cfg_master & sel_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ovf  <= 1'b0;
      irq_rxf <= 1'b0;
      irq_txe <= 1'b0;
    end else begin
      if (eng_push && rx_full) rx_ovf <= 1'b1;
      else if (rd_en)          rx_ovf <= 1'b0;
      irq_rxf <= cfg_fifo & rx_full;
      irq_txe <= cfg_fifo & tx_empty;
    end
  end

  AST_OVF_SET:    assert property (@(posedge clk) disable iff (rst) (eng_push && rx_full) |=> rx_ovf); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) (rx_ovf && !rd_en) |=> rx_ovf); // R7
endmodule

// File: tb/sim_spi_xcvr.sv
module sim_spi_xcvr;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_master = 1'b1, cfg_wide = 1'b0, cfg_fifo = 1'b0, cfg_selout = 1'b1;
  logic [7:0] cfg_half = 8'd2;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic tx_full, tx_empty, rx_full, rx_empty, rx_ovf, irq_rxf, irq_txe;
  logic sck_o, sel_n_o, sdo;
  logic sck_i = 1'b0, sel_n_i = 1'b1, bsdi = 1'b0;
  logic sdi_w;

  int errors = 0, checks = 0;
  bit done = 0;

  // master-side model of the far end
  logic [63:0] mreg = '0;
  logic [63:0] cap = '0;
  int rises = 0;
  longint t_prev = 0, t_last = 0;
  bit sel_seen = 0;

  assign sdi_w = cfg_master ? mreg[63] : bsdi;

  always #5 clk = ~clk;

  spi_xcvr u0 (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_wide(cfg_wide),
    .cfg_fifo(cfg_fifo), .cfg_selout(cfg_selout), .cfg_half(cfg_half),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .rx_ovf(rx_ovf), .irq_rxf(irq_rxf), .irq_txe(irq_txe),
    .sck_o(sck_o), .sel_n_o(sel_n_o), .sck_i(sck_i), .sel_n_i(sel_n_i),
    .sdi(sdi_w), .sdo(sdo)
  );

  always @(negedge sck_o) begin
    #1 mreg = {mreg[62:0], 1'b0};
  end

  always @(posedge sck_o) begin
    #1;
    cap = {cap[62:0], sdo};
    rises = rises + 1;
    t_prev = t_last;
    t_last = $time;
  end

  always @(negedge sel_n_o) sel_seen = 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [15:0] exq[$];
  string       exr[$];
  logic        rd_q = 1'b0;

  task automatic expect_rx(input logic [15:0] w, input string req);
    exq.push_back(w);
    exr.push_back(req);
  endtask

  always @(posedge clk) rd_q <= rd_en;

  always @(negedge clk) begin
    if (rd_q) begin
      if (exq.size() == 0) chk(1'b0, "R4 unexpected read", {48'h0, rd_data}, 64'h0);
      else begin
        logic [15:0] e;
        string r;
        e = exq.pop_front();
        r = exr.pop_front();
        chk(rd_data == e, r, {48'h0, rd_data}, {48'h0, e});
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic ext_xfer(input logic [15:0] mo, input int nb, output logic [15:0] mi);
    mi = '0;
    sel_n_i = 1'b0;
    for (int i = 0; i < nb; i++) begin
      bsdi = mo[nb-1-i];
      cyc(8);
      sck_i = 1'b1;
      mi = {mi[14:0], sdo};
      cyc(8);
      sck_i = 1'b0;
    end
    cyc(8);
    sel_n_i = 1'b1;
    cyc(8);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sck_o == 0 && sel_n_o == 1, "R1 pins", {62'h0, sck_o, sel_n_o}, 64'h1);
    chk(tx_empty && rx_empty && !rx_full && !tx_full, "R1 flags",
        {60'h0, tx_empty, rx_empty, rx_full, tx_full}, 64'hC);
    chk(!rx_ovf && !irq_rxf && !irq_txe, "R1 ovf/irq", {61'h0, rx_ovf, irq_rxf, irq_txe}, 64'h0);

    // T1: master 8-bit, select output enabled
    mreg = {8'h3C, 56'h0}; cap = '0; rises = 0; sel_seen = 0;
    cfg_half = 8'd2;
    wr(16'h00A5);
    cyc(80);
    chk(cap[7:0] == 8'hA5, "R2 master msb-first byte", cap[7:0], 64'hA5);
    chk(rises == 8, "R2 clock count", rises, 8);
    chk(t_last - t_prev == 40, "R2 sck period", t_last - t_prev, 40);
    chk(sck_o == 0, "R2 sck idle low", sck_o, 0);
    chk(sel_seen == 1 && sel_n_o == 1, "R9 select pulsed", {sel_seen, sel_n_o}, 2'b11);
    expect_rx(16'h003C, "R4 rx byte, upper zero");
    rd();

    // T2: master 16-bit
    mreg = {16'h1234, 48'h0}; cap = '0; rises = 0;
    cfg_wide = 1'b1; cfg_half = 8'd3;
    wr(16'hBEEF);
    cyc(230);
    chk(cap[15:0] == 16'hBEEF, "R3 16-bit frame out", cap[15:0], 64'hBEEF);
    chk(rises == 16, "R3 clock count", rises, 16);
    chk(t_last - t_prev == 60, "R3 sck period", t_last - t_prev, 60);
    expect_rx(16'h1234, "R3 16-bit frame in");
    rd();

    // T3: double buffer, dropped write, overflow, no select output
    mreg = {8'hC3, 8'h5A, 48'h0}; cap = '0; rises = 0; sel_seen = 0;
    cfg_wide = 1'b0; cfg_half = 8'd2; cfg_selout = 1'b0;
    wr(16'h0011);
    cyc(4);
    wr(16'h0022);
    chk(tx_full == 1, "R5 buffer full after second write", tx_full, 1);
    wr(16'h0033);
    cyc(200);
    chk(cap[15:0] == 16'h1122, "R5 back-to-back words", cap[15:0], 64'h1122);
    chk(rises == 16, "R5 full-buffer write dropped", rises, 16);
    chk(sel_seen == 0, "R9 select held high", sel_seen, 0);
    chk(rx_ovf == 1, "R7 overflow flagged", rx_ovf, 1);
    expect_rx(16'h00C3, "R7 first word kept");
    rd();
    chk(rx_ovf == 0 && rx_empty == 1, "R7 cleared, second word dropped", {rx_ovf, rx_empty}, 2'b01);
    cfg_selout = 1'b1;

    // T4: FIFO mode, 8 words each way
    cfg_fifo = 1'b1; cfg_half = 8'd1;
    mreg = 64'hF0E1D2C3B4A59687; cap = '0; rises = 0;
    wr(16'h0001); wr(16'h0023); wr(16'h0045); wr(16'h0067);
    wr(16'h0089); wr(16'h00AB); wr(16'h00CD); wr(16'h00EF);
    chk(irq_txe == 0, "R6 tx irq low while queued", irq_txe, 0);
    cyc(300);
    chk(cap == 64'h0123456789ABCDEF, "R6 eight words out", cap, 64'h0123456789ABCDEF);
    chk(rx_full == 1 && irq_rxf == 1, "R6 rx full + irq", {rx_full, irq_rxf}, 2'b11);
    chk(irq_txe == 1 && tx_empty == 1, "R6 tx empty irq", {irq_txe, tx_empty}, 2'b11);
    chk(rx_ovf == 0, "R6 eight fit without overflow", rx_ovf, 0);
    expect_rx(16'h00F0, "R6 fifo 0"); expect_rx(16'h00E1, "R6 fifo 1");
    expect_rx(16'h00D2, "R6 fifo 2"); expect_rx(16'h00C3, "R6 fifo 3");
    expect_rx(16'h00B4, "R6 fifo 4"); expect_rx(16'h00A5, "R6 fifo 5");
    expect_rx(16'h0096, "R6 fifo 6"); expect_rx(16'h0087, "R6 fifo 7");
    for (int i = 0; i < 8; i++) rd();
    cyc(2);
    chk(rx_empty == 1 && irq_rxf == 0, "R6 drained", {rx_empty, irq_rxf}, 2'b10);
    cfg_fifo = 1'b0;

    // T5: slave 16-bit exchange
    cfg_master = 1'b0; cfg_wide = 1'b1;
    cyc(4);
    wr(16'hA1B2);
    cyc(4);
    ext_xfer(16'h5C3D, 16, got);
    chk(got == 16'hA1B2, "R10 slave sends word", got, 16'hA1B2);
    expect_rx(16'h5C3D, "R10 slave receives word");
    rd();

    // T6: slave ignores clock while deselected, then 8-bit exchange
    cfg_wide = 1'b0;
    wr(16'h0096);
    cyc(4);
    for (int i = 0; i < 4; i++) begin
      sck_i = 1'b1; cyc(8);
      sck_i = 1'b0; cyc(8);
    end
    chk(rx_empty == 1, "R8 no frame while deselected", rx_empty, 1);
    chk(tx_empty == 0, "R8 word not taken while deselected", tx_empty, 0);
    ext_xfer(16'h004B, 8, got);
    chk(got[7:0] == 8'h96, "R8 clean exchange after idle clocks", got[7:0], 8'h96);
    expect_rx(16'h004B, "R10 slave 8-bit receive");
    rd();

    chk(exq.size() == 0, "R4 scoreboard drained", exq.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule